// File: doc/BRIEF.md
# Three-Level Noise-Shaping Bridge Modulator

This block turns a stream of signed audio samples, one per modulator clock, into the two single-bit drive signals of a filterless bridge-tied speaker load. A second-order noise-shaping loop makes a ternary decision on every clock. A positive decision raises the plus drive and lowers the minus drive. A negative decision does the opposite. A zero decision puts both drives on the same rail, so the load sees no differential voltage.

Because the loop rests at zero rather than toggling at a fixed carrier, differential pulses appear only when the accumulated error calls for one. The pulse density follows the input level, and the spectrum is spread, so several instances need no common clock phase. Both loop integrators saturate, which keeps the loop stable under overload. During a zero run the common rail alternates between runs, which shares switching wear between the two half-bridges. Deasserting the enable input silences the outputs and clears the loop.

Top module: `tsd_modulator`

## Requirements
- R1: Output encoding: `drv_p`=1,`drv_n`=0 is a positive pulse; `drv_p`=0,`drv_n`=1 is a negative pulse; equal values are the zero state. Outputs are registered and reflect the input present before the same clock edge.
- R2: While the input is zero, every output cycle is in the zero state.
- R3: While the input is positive, no negative pulse is produced. While the input is negative, no positive pulse is produced.
- R4: For a constant input of magnitude M (at most half of full scale, FS = 2^(DATA_W-1)-1), the number of pulses in 1024 cycles, after 64 cycles of settling, is within 24 of M*1024/FS.
- R5: When input +FS or -FS is applied after enable, the output is zero in the first cycle and carries a pulse of the matching polarity in every later cycle.
- R6: The most negative input code (bit DATA_W-1 set, all other bits clear) behaves exactly as -FS.
- R7: The zero state sits low on its first run after enable or reset. Each later zero run that follows a pulse uses the opposite rail from the previous run, and a run keeps one level throughout.
- R8: A clock edge with `en` low drives both outputs low and clears the loop, so the same input sequence after re-enable yields the same output sequence.
- R9: After a switch between +FS and -FS held for hundreds of cycles, the output carries a pulse of the new polarity on every cycle from the 16th cycle onward.
- R10: A clock edge with `rst_n` low drives both outputs low, whatever the state of `en` and the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Modulator enable; low silences the outputs and clears the loop |
| sample_i | input | DATA_W | Signed two's-complement audio sample, read every clock |
| drv_p | output | 1 | Drive bit of the plus half-bridge |
| drv_n | output | 1 | Drive bit of the minus half-bridge |

## Verification
Two functions can act in the same cycle. One is the polarity gate, which vetoes a decision opposite to the current input sign. The other is the integrator clamp, which limits the loop state. Both occur when the input jumps from one full-scale polarity to the other while the second integrator is pinned at its limit. The bench holds each full-scale polarity for hundreds of cycles, reverses it, and checks every cycle that no pulse of the old polarity leaks out. It also checks that the new polarity fills every cycle within the recovery bound. A second pairing is the rail flip at the start of a zero run against a disable arriving in the same cycle. The bench judges this through the rail rule, which must restart low after every enable.

// File: rtl/tsd_pkg.sv
// Package: shared types and sizing helpers of the three-level modulator.
// Assumes: users derive every width from the data width and clamp factor.
package tsd_pkg;

    // Ternary decision of the quantiser
    typedef enum logic [1:0] {
        TRI_ZERO = 2'b00,
        TRI_POS  = 2'b01,
        TRI_NEG  = 2'b10
    } tri_e;

    // Full-scale magnitude of a signed sample of the given width
    function automatic int fs_mag(input int dw);
        return (1 << (dw - 1)) - 1;
    endfunction

    // Integrator width: sample width plus headroom for the clamp factor
    function automatic int acc_width(input int dw, input int cm);
        return dw + $clog2(cm) + 2;
    endfunction

endpackage

// File: rtl/tsd_sat_integ.sv
// Saturating accumulator stage of the noise-shaping loop.
// Adds a signed delta each clock and limits the result to +/-LIM.
// Assumes: delta and the stored value fit the extended sum width.
// Exposes the next value combinationally so the stages can be chained.
module tsd_sat_integ #(
    parameter int ACC_W = 20,
    parameter int LIM   = 131068
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic signed [ACC_W+1:0] delta,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [ACC_W-1:0] acc_nxt
);
    localparam logic signed [ACC_W+1:0] HI = (ACC_W+2)'(LIM);
    localparam logic signed [ACC_W+1:0] LO = -HI;

    logic signed [ACC_W+1:0] sum;

    // Extended sum followed by the clamp to the symmetric limit
    always_comb begin
        sum = {{2{acc_q[ACC_W-1]}}, acc_q} + delta;
        if (sum > HI) begin
            acc_nxt = HI[ACC_W-1:0];
        end else if (sum < LO) begin
            acc_nxt = LO[ACC_W-1:0];
        end else begin
            acc_nxt = sum[ACC_W-1:0];
        end
    end

    // State register, cleared by reset or by the loop clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/tsd_loop_filter.sv
// Second-order error-feedback loop filter built from saturating stages.
// Each stage takes its input (the sample, then the previous stage's next
// value) minus the fed-back decision scaled to full scale.
// Assumes: dec is the decision taken from the current last-stage state.
module tsd_loop_filter
    import tsd_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CLAMP_MULT = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      clr,
    input  logic signed [DATA_W-1:0]                  x_eff,
    input  tri_e                                      dec,
    output logic signed [acc_width(DATA_W, CLAMP_MULT)-1:0] state_o
);
    localparam int ACC_W  = acc_width(DATA_W, CLAMP_MULT);
    localparam int FS     = fs_mag(DATA_W);
    localparam int LIM    = CLAMP_MULT * FS;
    localparam int STAGES = 2;
    localparam logic signed [ACC_W+1:0] FBW = (ACC_W+2)'(FS);

    logic signed [ACC_W+1:0] fb_w;
    logic signed [ACC_W+1:0] x_ext;
    logic signed [ACC_W+1:0] delta   [STAGES];
    logic signed [ACC_W-1:0] acc_q   [STAGES];
    logic signed [ACC_W-1:0] acc_nxt [STAGES];

    // Feedback value of the ternary decision
    always_comb begin
        case (dec)
            TRI_POS: fb_w = FBW;
            TRI_NEG: fb_w = -FBW;
            default: fb_w = '0;
        endcase
    end

    assign x_ext = {{(ACC_W+2-DATA_W){x_eff[DATA_W-1]}}, x_eff};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign delta[g] = x_ext - fb_w;
        end else begin : g_chain
            assign delta[g] = {{2{acc_nxt[g-1][ACC_W-1]}}, acc_nxt[g-1]} - fb_w;
        end
        tsd_sat_integ #(
            .ACC_W (ACC_W),
            .LIM   (LIM)
        ) integ_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .delta   (delta[g]),
            .acc_q   (acc_q[g]),
            .acc_nxt (acc_nxt[g])
        );
    end

    assign state_o = acc_q[STAGES-1];

endmodule

// File: rtl/tsd_quantizer.sv
// Ternary quantiser with a polarity gate.
// Compares the loop state against +/-half full scale. A pulse is allowed
// only when it has the same sign as the present sample, so a zero sample
// never produces a pulse.
// Assumes: state and sample are signed two's complement.
module tsd_quantizer
    import tsd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 20
) (
    input  logic signed [ACC_W-1:0]  state_i,
    input  logic signed [DATA_W-1:0] x_eff,
    output tri_e                     dec
);
    localparam logic signed [ACC_W-1:0] THR = ACC_W'(fs_mag(DATA_W) / 2);

    logic want_pos, want_neg;

    // Threshold compare gated by the sign of the sample
    always_comb begin
        want_pos = (state_i >= THR)  && (x_eff > 0);
        want_neg = (state_i <= -THR) && (x_eff < 0);
        if (want_pos) begin
            dec = TRI_POS;
        end else if (want_neg) begin
            dec = TRI_NEG;
        end else begin
            dec = TRI_ZERO;
        end
    end

endmodule

// File: rtl/tsd_drive_map.sv
// Maps the ternary decision onto the two registered drive bits.
// In the zero state both drives take a common rail. The rail flips at the
// first zero cycle after any pulse and starts low after enable or reset.
// Assumes: en low must silence the drives on the same edge.
module tsd_drive_map
    import tsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  tri_e dec,
    output logic drv_p,
    output logic drv_n
);
    logic rest_lvl;
    logic after_pulse;
    logic zero_lvl;

    // Rail for a zero cycle: flipped if the previous cycle carried a pulse
    always_comb begin
        zero_lvl = after_pulse ? ~rest_lvl : rest_lvl;
    end

    // Output and rail-tracking registers
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            drv_p       <= 1'b0;
            drv_n       <= 1'b0;
            rest_lvl    <= 1'b0;
            after_pulse <= 1'b0;
        end else begin
            case (dec)
                TRI_POS: begin
                    drv_p       <= 1'b1;
                    drv_n       <= 1'b0;
                    after_pulse <= 1'b1;
                end
                TRI_NEG: begin
                    drv_p       <= 1'b0;
                    drv_n       <= 1'b1;
                    after_pulse <= 1'b1;
                end
                default: begin
                    drv_p       <= zero_lvl;
                    drv_n       <= zero_lvl;
                    rest_lvl    <= zero_lvl;
                    after_pulse <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/tsd_modulator.sv
// Top of the three-level noise-shaping bridge modulator.
// Folds the most negative code onto -full scale, runs the loop filter,
// quantises to a ternary decision and registers the two drive bits.
// Assumes: one sample per clock; synchronous active-low reset.
module tsd_modulator
    import tsd_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CLAMP_MULT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] sample_i,
    output logic              drv_p,
    output logic              drv_n
);
    localparam int ACC_W = acc_width(DATA_W, CLAMP_MULT);
    localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] x_eff;
    logic signed [ACC_W-1:0]  loop_state;
    tri_e                     dec;

    // Symmetric input range: most negative code becomes -full scale
    always_comb begin
        if (sample_i == MIN_CODE) begin
            x_eff = signed'(MIN_CODE + 1'b1);
        end else begin
            x_eff = signed'(sample_i);
        end
    end

    tsd_loop_filter #(
        .DATA_W     (DATA_W),
        .CLAMP_MULT (CLAMP_MULT)
    ) loop_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!en),
        .x_eff   (x_eff),
        .dec     (dec),
        .state_o (loop_state)
    );

    tsd_quantizer #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) quant_i (
        .state_i (loop_state),
        .x_eff   (x_eff),
        .dec     (dec)
    );

    tsd_drive_map map_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .dec   (dec),
        .drv_p (drv_p),
        .drv_n (drv_n)
    );

endmodule

// File: rtl/tsd_modulator_chk.sv
// Checker for the modulator ports, attached by bind.
// Keeps one- and two-cycle delayed copies of the inputs and outputs so each
// output can be related to the inputs that produced it.
module tsd_modulator_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DATA_W-1:0] sample_i,
    input logic              drv_p,
    input logic              drv_n
);
    logic                     live;
    logic                     rst_d, rst_dd;
    logic                     en_d, en_dd;
    logic signed [DATA_W-1:0] x_d;
    logic                     p_d, n_d;

    // Delayed copies of ports for the properties
    always_ff @(posedge clk) begin
        live   <= 1'b1;
        rst_d  <= rst_n;
        rst_dd <= rst_d;
        en_d   <= en;
        en_dd  <= en_d;
        x_d    <= signed'(sample_i);
        p_d    <= drv_p;
        n_d    <= drv_n;
    end

    // R10: a reset edge leaves both drives low
    a_r10_reset_quiet: assert property (@(posedge clk)
        (live && !rst_d) |-> (!drv_p && !drv_n));

    // R8: a disabled edge leaves both drives low
    a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !en_d) |-> (!drv_p && !drv_n));

    // R2: zero input gives the zero state
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (live && rst_d && en_d && (x_d == 0)) |-> (drv_p == drv_n));

    // R3: positive input never yields a negative pulse
    a_r3_pos_only: assert property (@(posedge clk) disable iff (!rst_n)
        (live && rst_d && en_d && (x_d > 0)) |-> !(!drv_p && drv_n));

    // R3: negative input never yields a positive pulse
    a_r3_neg_only: assert property (@(posedge clk) disable iff (!rst_n)
        (live && rst_d && en_d && (x_d < 0)) |-> !(drv_p && !drv_n));

    // R7: consecutive zero-state cycles keep one rail
    a_r7_run_level: assert property (@(posedge clk) disable iff (!rst_n)
        (live && rst_d && rst_dd && en_d && en_dd && (drv_p == drv_n) && (p_d == n_d))
        |-> (drv_p == p_d));

endmodule

bind tsd_modulator tsd_modulator_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .sample_i (sample_i),
    .drv_p    (drv_p),
    .drv_n    (drv_n)
);

// File: tb/tsd_modulator_tb_top.sv
// Bench for the three-level modulator: random constant levels plus directed
// full-scale, reversal, idle and re-enable cases, judged by a cycle monitor.
module tsd_modulator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int FS         = 32767;
    localparam logic [W-1:0] MIN_CODE = 16'h8000;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         en    = 1'b1;
    logic [W-1:0] x     = '0;
    logic         drv_p, drv_n;

    int n_checks = 0;
    int n_fail   = 0;
    int npos, nneg, nruns, nhigh;
    bit exp_lvl, after_pulse, done;
    logic [1:0] rec_a [64];
    logic [1:0] rec_b [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    tsd_modulator #(.DATA_W(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sample_i (x),
        .drv_p    (drv_p),
        .drv_n    (drv_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle judgement of the outputs against the input that produced them
    task automatic observe();
        int xs;
        xs = int'(signed'(x));
        if (!rst_n) begin
            check(!drv_p && !drv_n, "R10", "drives during reset", {drv_p, drv_n}, 0);
            exp_lvl = 0; after_pulse = 0;
        end else if (!en) begin
            check(!drv_p && !drv_n, "R8", "drives while disabled", {drv_p, drv_n}, 0);
            exp_lvl = 0; after_pulse = 0;
        end else if (drv_p && !drv_n) begin
            npos++; after_pulse = 1;
            check(xs > 0, "R3", "positive pulse with input", xs, 1);
        end else if (!drv_p && drv_n) begin
            nneg++; after_pulse = 1;
            check(xs < 0, "R3", "negative pulse with input", xs, -1);
        end else begin
            if (after_pulse) begin
                exp_lvl = !exp_lvl; after_pulse = 0; nruns++;
                if (exp_lvl) nhigh++;
            end
            check(drv_p == exp_lvl, "R7", "zero-state rail", drv_p, exp_lvl);
        end
    endtask

    task automatic step(input logic [W-1:0] nx, input bit nen);
        @(negedge clk);
        observe();
        x  = nx;
        en = nen;
    endtask

    task automatic run(input logic [W-1:0] nx, input bit nen, input int n);
        for (int i = 0; i < n; i++) step(nx, nen);
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return W'(((i * 7919) % 40000) - 20000);
    endfunction

    function automatic int exp_count(input int mag, input int n);
        return int'((longint'(mag) * n) / FS);
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed_v, mag, sv, cnt, opp, mism;
        seed_v = int'($urandom(32'd4711));

        // R10: reset dominates enable and a full-scale input
        run(16'(FS), 1, 4);
        rst_n = 1'b1;
        run('0, 0, 2);

        // R2: idle input, enabled for a long stretch
        run('0, 1, 4);
        npos = 0; nneg = 0;
        run('0, 1, 300);
        check(npos + nneg == 0, "R2", "pulses on zero input", npos + nneg, 0);

        // R4/R3: random constant levels plus one directed level
        for (int k = 0; k < 7; k++) begin
            if (k == 0) mag = FS / 4;
            else mag = 2048 + int'($urandom % 14336);
            sv = (k != 0 && $urandom % 2 == 1) ? -mag : mag;
            run(W'(sv), 1, 64);
            npos = 0; nneg = 0;
            run(W'(sv), 1, 1024);
            cnt = (sv > 0) ? npos : nneg;
            opp = (sv > 0) ? nneg : npos;
            check((cnt - exp_count(mag, 1024) <= 24) && (exp_count(mag, 1024) - cnt <= 24),
                  "R4", "pulse count", cnt, exp_count(mag, 1024));
            check(opp == 0, "R3", "opposite pulses", opp, 0);
        end

        // R7: sparse pulses produce many zero runs on alternating rails
        run('0, 0, 2);
        nruns = 0; nhigh = 0;
        run(16'(FS / 8), 1, 400);
        check(nruns >= 10, "R7", "zero runs after pulses", nruns, 10);
        check(nhigh * 2 >= nruns - 1 && nhigh * 2 <= nruns + 1, "R7", "high-rail runs", nhigh, nruns / 2);

        // R5/R1: positive full scale from a cleared loop
        run('0, 0, 2);
        run(16'(FS), 1, 2);
        check(drv_p == drv_n, "R5", "first enabled cycle is zero", {drv_p, drv_n}, 0);
        step(16'(FS), 1);
        check({drv_p, drv_n} == 2'b10, "R1", "positive encoding", {drv_p, drv_n}, 2);
        npos = 0;
        run(16'(FS), 1, 200);
        check(npos == 200, "R5", "positive every cycle", npos, 200);

        // R5: negative full scale
        run('0, 0, 2);
        run(W'(-FS), 1, 3);
        check({drv_p, drv_n} == 2'b01, "R1", "negative encoding", {drv_p, drv_n}, 1);
        nneg = 0;
        run(W'(-FS), 1, 200);
        check(nneg == 200, "R5", "negative every cycle", nneg, 200);

        // R6: most negative code behaves as -FS
        run('0, 0, 2);
        run(MIN_CODE, 1, 2);
        check(drv_p == drv_n, "R6", "first cycle zero", {drv_p, drv_n}, 0);
        nneg = 0;
        run(MIN_CODE, 1, 200);
        check(nneg == 200, "R6", "negative every cycle", nneg, 200);

        // R9: full-scale reversals with the integrators pinned
        run('0, 0, 2);
        run(16'(FS), 1, 300);
        run(W'(-FS), 1, 16);
        nneg = 0;
        run(W'(-FS), 1, 100);
        check(nneg == 100, "R9", "negative after reversal", nneg, 100);
        run(16'(FS), 1, 16);
        npos = 0;
        run(16'(FS), 1, 100);
        check(npos == 100, "R9", "positive after reversal", npos, 100);

        // R8: disable clears the loop, so a replay repeats the output
        run('0, 0, 3);
        for (int i = 0; i < 64; i++) begin
            step(pat(i), 1);
            rec_a[i] = {drv_p, drv_n};
        end
        run(16'(FS), 0, 3);
        for (int i = 0; i < 64; i++) begin
            step(pat(i), 1);
            rec_b[i] = {drv_p, drv_n};
        end
        mism = 0;
        for (int i = 0; i < 64; i++) if (rec_a[i] != rec_b[i]) mism++;
        check(mism == 0, "R8", "replay mismatches", mism, 0);

        run('0, 0, 2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule